// File: doc/BRIEF.md
# SPI Master with Chip-Select Timing Control

This block is a single-slave SPI master that moves one word per transfer, MSB first, in any of the four clock polarity/phase modes. It owns the chip-select pin and shapes the gaps around the serial clock. A setup gap comes between chip-select falling and the first clock edge, and a hold gap comes between the last clock edge and chip-select rising. Each gap has a phase-dependent minimum, and a 5-bit field adds extra system clocks to it. The serial clock period is 2×(`cfg_div`+1) system clocks.

A keep flag lets queued words run back to back while chip-select stays low. In slave-ready mode the master only starts a word once the `slv_rdy` input, passed through a two-stage synchronizer, is high. A slave can therefore stall the next word by pulling the line low after the final clock edge. Configuration must stay stable while `busy` is high.

The controller is a five-state machine. IDLE has chip-select high and `sclk` following `cfg_cpol`; an accepted word moves it to SETUP. WAIT_RDY holds chip-select low with a queued word until the gate opens, and an accepted word moves it to SETUP. SETUP counts the setup gap; its end is the first clock edge, leading to SHIFT. SHIFT produces the remaining edges, one every `cfg_div`+1 cycles, and moves to HOLD on the last edge. When the HOLD count ends the machine goes to one of three states. It goes to SETUP when keep is set and the next word is accepted, and to WAIT_RDY when keep is set and a word is valid but the gate is closed. Otherwise it goes to IDLE.

Top module: `spi_csm_master`

## Requirements
- R1: While `cs_n` is high, `sclk` rests at `cfg_cpol`, following it one cycle later. It is also at that level when `cs_n` falls, so the first edge of a word is rising for polarity 0 and falling for polarity 1.
- R2: Within a word, consecutive `sclk` transitions are exactly `cfg_div`+1 system clocks apart.
- R3: The first `sclk` transition after `cs_n` falls comes exactly 2+`cfg_setup_dly` cycles later with phase 0, and (`cfg_div`+1)+2+`cfg_setup_dly` cycles later with phase 1.
- R4: `cs_n` rises exactly `cfg_div`+1+1+`cfg_hold_dly` cycles after the final `sclk` transition with phase 0, and 1+`cfg_hold_dly` cycles after it with phase 1.
- R5: Data is MSB first. With phase 0 the first bit is on `mosi` when `cs_n` falls, MISO is sampled on odd-numbered transitions (1st, 3rd, …) and `mosi` changes on the even-numbered ones. Phase 1 swaps this: `mosi` changes on the odd-numbered transitions and MISO is sampled on the even-numbered ones. With `miso` looped to `mosi` (or inverted), `rx_data` equals the sent word (or its complement).
- R6: `rx_valid` is a one-cycle pulse, raised at the same clock edge as the final sampling transition of `sclk`, while `cs_n` is low.
- R7: With `cfg_keep_cs`=1 and the next word valid when the hold gap ends, `cs_n` stays low into the next word. With `cfg_keep_cs`=0, `cs_n` goes high between words.
- R8: With `cfg_rdy_mode`=1, no word is accepted (`tx_ready`=0, `cs_n` stays high) while `slv_rdy` is low. After `slv_rdy` rises, `cs_n` falls on the third clock edge.
- R9: After reset `cs_n`=1, `busy`=0, `rx_valid`=0 and `tx_ready`=1 (gate open). `busy` is high exactly while `cs_n` is low.
- R10: Each chip-select window contains exactly 2×`WORD_W` `sclk` transitions per word sent in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_div | input | DIV_W | Half-period of SPI clock minus one, in system clocks |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_setup_dly | input | 5 | Extra cycles before the first clock edge |
| cfg_hold_dly | input | 5 | Extra cycles after the final clock edge |
| cfg_keep_cs | input | 1 | Keep chip-select low across queued words |
| cfg_rdy_mode | input | 1 | Gate each start on the slave-ready input |
| tx_valid | input | 1 | Transmit word valid |
| tx_data | input | WORD_W | Transmit word |
| tx_ready | output | 1 | Word accepted this cycle when valid |
| rx_valid | output | 1 | Received-word pulse |
| rx_data | output | WORD_W | Received word |
| busy | output | 1 | Chip-select window active |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Chip-select, active low |
| miso | input | 1 | Serial data in |
| slv_rdy | input | 1 | Slave ready, asynchronous |

## Verification
Every result has a fixed number of clock edges after its cause. `cs_n` falls one edge after acceptance, or three edges after `slv_rdy` rises when the gate was closed. The first `sclk` transition follows the setup length counted from that fall, and each later transition follows `cfg_div`+1 edges after the one before. `rx_valid` rises together with the final sampling transition, and `cs_n` rises after the hold length counted from the last transition. The bench drives on falling edges and samples on falling edges, counting falling edges between observed transitions, so every measured gap is compared with the exact count derived from the configuration.

// File: rtl/spi_csm_pkg.sv
package spi_csm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_RDY,
        ST_SETUP,
        ST_SHIFT,
        ST_HOLD
    } spi_state_t;

endpackage

// File: rtl/spi_csm_sync.sv
module spi_csm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[STAGES-2:0], d};
        end
    end

    assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/spi_csm_timer.sv
module spi_csm_timer #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    // Count from zero after each restart and park at the limit.
    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (!last) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign last = (cnt_q == limit);

endmodule

// File: rtl/spi_csm_shift.sv
module spi_csm_shift #(
    parameter int WORD_W = 8,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              edge_stb,
    input  logic [IDX_W-1:0]  edge_idx,
    input  logic              cpha,
    input  logic              miso,
    output logic              mosi,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_done
);

    logic [WORD_W-1:0] tx_sr_q;
    logic [WORD_W-1:0] rx_sr_q;
    logic              sample;
    logic              drive;
    logic              final_pair;

    // Edge parity picks the role: phase 0 samples on even indices,
    // phase 1 on odd ones; the other parity shifts the next bit out.
    assign sample     = edge_stb && (edge_idx[0] == cpha);
    assign drive      = edge_stb && (edge_idx[0] != cpha) && (edge_idx != '0);
    assign final_pair = (edge_idx[IDX_W-1:1] == (IDX_W-1)'(WORD_W-1));

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sr_q <= '0;
            rx_sr_q <= '0;
            rx_done <= 1'b0;
        end else begin
            rx_done <= sample && final_pair;
            if (load) begin
                tx_sr_q <= load_word;
            end else if (drive) begin
                tx_sr_q <= {tx_sr_q[WORD_W-2:0], 1'b0};
            end
            if (sample) begin
                rx_sr_q <= {rx_sr_q[WORD_W-2:0], miso};
            end
        end
    end

    assign mosi    = tx_sr_q[WORD_W-1];
    assign rx_word = rx_sr_q;

endmodule

// File: rtl/spi_csm_master.sv
module spi_csm_master
    import spi_csm_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic [4:0]        cfg_setup_dly,
    input  logic [4:0]        cfg_hold_dly,
    input  logic              cfg_keep_cs,
    input  logic              cfg_rdy_mode,
    input  logic              tx_valid,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              rx_valid,
    output logic [WORD_W-1:0] rx_data,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n,
    input  logic              miso,
    input  logic              slv_rdy
);

    localparam int EDGES = 2 * WORD_W;
    localparam int IDX_W = $clog2(EDGES);
    localparam int CNT_W = DIV_W + 6;

    spi_state_t       state_q, state_d;
    logic             rdy_sync;
    logic             gate_ok;
    logic             tm_last;
    logic             accept;
    logic             edge_stb;
    logic             restart;
    logic             last_edge;
    logic             sclk_q;
    logic [CNT_W-1:0] half_len;
    logic [CNT_W-1:0] setup_len;
    logic [CNT_W-1:0] hold_len;
    logic [CNT_W-1:0] tm_limit;
    logic [IDX_W-1:0] edge_idx_q;

    spi_csm_sync #(.STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (slv_rdy),
        .q   (rdy_sync)
    );

    assign gate_ok   = !cfg_rdy_mode || rdy_sync;
    assign half_len  = CNT_W'(cfg_div) + CNT_W'(1);
    assign setup_len = CNT_W'(2) + CNT_W'(cfg_setup_dly) + (cfg_cpha ? half_len : '0);
    assign hold_len  = CNT_W'(1) + CNT_W'(cfg_hold_dly) + (cfg_cpha ? '0 : half_len);
    assign last_edge = (edge_idx_q == IDX_W'(EDGES - 1));
    assign accept    = tx_valid && tx_ready;
    assign restart   = accept || edge_stb;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = ST_SETUP;
            end
            ST_WAIT_RDY: begin
                if (accept) state_d = ST_SETUP;
            end
            ST_SETUP: begin
                if (tm_last) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (tm_last && last_edge) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (tm_last) begin
                    if (accept) begin
                        state_d = ST_SETUP;
                    end else if (cfg_keep_cs && tx_valid) begin
                        state_d = ST_WAIT_RDY;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs and per-state controls.
    always_comb begin
        cs_n     = 1'b0;
        tx_ready = 1'b0;
        edge_stb = 1'b0;
        tm_limit = half_len - CNT_W'(1);
        unique case (state_q)
            ST_IDLE: begin
                cs_n     = 1'b1;
                tx_ready = gate_ok;
            end
            ST_WAIT_RDY: begin
                tx_ready = gate_ok;
            end
            ST_SETUP: begin
                tm_limit = setup_len - CNT_W'(1);
                edge_stb = tm_last;
            end
            ST_SHIFT: begin
                edge_stb = tm_last;
            end
            ST_HOLD: begin
                tm_limit = hold_len - CNT_W'(1);
                tx_ready = gate_ok && tm_last && cfg_keep_cs;
            end
            default: cs_n = 1'b1;
        endcase
    end

    assign busy = (state_q != ST_IDLE);

    // Edge index and serial clock.
    always_ff @(posedge clk) begin
        if (rst) begin
            edge_idx_q <= '0;
            sclk_q     <= cfg_cpol;
        end else begin
            if (accept) begin
                edge_idx_q <= '0;
            end else if (edge_stb) begin
                edge_idx_q <= edge_idx_q + IDX_W'(1);
            end
            if (state_q == ST_IDLE) begin
                sclk_q <= cfg_cpol;
            end else if (edge_stb) begin
                sclk_q <= ~sclk_q;
            end
        end
    end

    assign sclk = sclk_q;

    spi_csm_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .limit   (tm_limit),
        .last    (tm_last)
    );

    spi_csm_shift #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .load_word (tx_data),
        .edge_stb  (edge_stb),
        .edge_idx  (edge_idx_q),
        .cpha      (cfg_cpha),
        .miso      (miso),
        .mosi      (mosi),
        .rx_word   (rx_data),
        .rx_done   (rx_valid)
    );

endmodule

// File: rtl/spi_csm_checker.sv
module spi_csm_checker #(
    parameter int WORD_W = 8,
    parameter int DIV_W  = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [DIV_W-1:0] cfg_div,
    input logic             cfg_cpol,
    input logic             cfg_cpha,
    input logic [4:0]       cfg_setup_dly,
    input logic [4:0]       cfg_hold_dly,
    input logic             cfg_rdy_mode,
    input logic             sclk,
    input logic             cs_n,
    input logic             rx_valid,
    input logic             slv_rdy
);

    localparam int EDGES = 2 * WORD_W;
    localparam int SAT   = 65535;

    logic sclk_d;
    logic toggled;
    int   cs_age;
    int   tog_age;
    int   tog_cnt;
    int   half_exp;
    int   setup_exp;
    int   hold_exp;

    assign toggled   = (sclk != sclk_d);
    assign half_exp  = int'(cfg_div) + 1;
    assign setup_exp = 2 + int'(cfg_setup_dly) + (cfg_cpha ? half_exp : 0);
    assign hold_exp  = 1 + int'(cfg_hold_dly) + (cfg_cpha ? 0 : half_exp);

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d  <= sclk;
            cs_age  <= 0;
            tog_age <= 0;
            tog_cnt <= 0;
        end else begin
            sclk_d  <= sclk;
            cs_age  <= cs_n ? 0 : ((cs_age < SAT) ? cs_age + 1 : cs_age);
            tog_age <= toggled ? 1 : ((tog_age < SAT) ? tog_age + 1 : tog_age);
            tog_cnt <= cs_n ? 0 : (toggled ? tog_cnt + 1 : tog_cnt);
        end
    end

    a_r1_idle_level: assert property (@(posedge clk) disable iff (rst)
        cs_n && $past(cs_n) |-> sclk == $past(cfg_cpol));

    a_r2_half_period: assert property (@(posedge clk) disable iff (rst)
        !cs_n && toggled && (tog_cnt % EDGES) != 0 |-> tog_age == half_exp);

    a_r3_setup_gap: assert property (@(posedge clk) disable iff (rst)
        !cs_n && toggled && tog_cnt == 0 |-> cs_age == setup_exp);

    a_r4_hold_gap: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> tog_age == hold_exp);

    a_r6_rx_pulse: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> !cs_n && toggled);

    a_r6_rx_single: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    a_r8_rdy_gate: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) && cfg_rdy_mode |-> $past(slv_rdy, 3));

    a_r10_edge_count: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> tog_cnt != 0 && (tog_cnt % EDGES) == 0);

endmodule

bind spi_csm_master spi_csm_checker #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_chk (.*);

// File: tb/spi_csm_master_test.sv
module spi_csm_master_test;

    localparam int W     = 8;
    localparam int DW    = 8;
    localparam int EDGES = 2 * W;

    logic          clk = 1'b0;
    logic          rst;
    logic [DW-1:0] cfg_div;
    logic          cfg_cpol, cfg_cpha, cfg_keep_cs, cfg_rdy_mode;
    logic [4:0]    cfg_setup_dly, cfg_hold_dly;
    logic          tx_valid;
    logic [W-1:0]  tx_data;
    logic          tx_ready, rx_valid, busy, sclk, mosi, cs_n, miso, slv_rdy;
    logic [W-1:0]  rx_data;
    logic          inv;

    int checks = 0;
    int errors = 0;
    int cs_rises = 0;
    int exp_words = 1;
    logic [W-1:0] sb_q[$];

    always #4 clk = ~clk;
    assign miso = mosi ^ inv;

    spi_csm_master #(.WORD_W(W), .DIV_W(DW)) uut (
        .clk, .rst, .cfg_div, .cfg_cpol, .cfg_cpha, .cfg_setup_dly, .cfg_hold_dly,
        .cfg_keep_cs, .cfg_rdy_mode, .tx_valid, .tx_data, .tx_ready, .rx_valid,
        .rx_data, .busy, .sclk, .mosi, .cs_n, .miso, .slv_rdy
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int half_len();
        return int'(cfg_div) + 1;
    endfunction
    function automatic int setup_len();
        return 2 + int'(cfg_setup_dly) + (cfg_cpha ? half_len() : 0);
    endfunction
    function automatic int hold_len();
        return 1 + int'(cfg_hold_dly) + (cfg_cpha ? 0 : half_len());
    endfunction

    // Driver: present a word, push its expected echo, wait for acceptance.
    task automatic send(input logic [W-1:0] w);
        tx_data  = w;
        tx_valid = 1'b1;
        sb_q.push_back(w ^ {W{inv}});
        forever begin
            #1;
            if (tx_ready) break;
            @(negedge clk);
        end
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!(cs_n && sb_q.size() == 0 && !tx_valid));
        repeat (3) @(negedge clk);
        chk(sclk == cfg_cpol, "R1", "idle sclk level", sclk, cfg_cpol);
    endtask

    // Monitor: timing measurements and scoreboard pop, sampled on falling edges.
    logic prev_cs = 1'b1;
    logic prev_sclk = 1'b0;
    int   cs_age = 0;
    int   tog_age = 0;
    int   tog_cnt = 0;

    always @(negedge clk) begin
        if (rst) begin
            prev_cs   = 1'b1;
            prev_sclk = sclk;
            cs_age    = 0;
            tog_age   = 0;
            tog_cnt   = 0;
        end else begin
            bit tg;
            logic [W-1:0] exp_w;
            tg = (sclk != prev_sclk);
            if (!cs_n) begin
                cs_age++;
                if (prev_cs)
                    chk(busy == 1'b1, "R9", "busy at window start", busy, 1);
                if (tg) begin
                    if (tog_cnt == 0)
                        chk(cs_age - 1 == setup_len(), "R3", "setup gap", cs_age - 1, setup_len());
                    else if (tog_cnt % EDGES != 0)
                        chk(tog_age + 1 == half_len(), "R2", "half period", tog_age + 1, half_len());
                    tog_cnt++;
                end
            end
            tog_age = tg ? 0 : tog_age + 1;
            if (cs_n && !prev_cs) begin
                chk(tog_age == hold_len(), "R4", "hold gap", tog_age, hold_len());
                chk(tog_cnt == EDGES * exp_words, "R10", "edges per window", tog_cnt, EDGES * exp_words);
                chk(busy == 1'b0, "R9", "busy after window", busy, 0);
                cs_rises++;
                tog_cnt = 0;
            end
            if (cs_n) cs_age = 0;
            if (rx_valid) begin
                chk(!cs_n && tg, "R6", "rx pulse with final sampling edge", int'(tg), 1);
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R5", "unexpected word", int'(rx_data), -1);
                end else begin
                    exp_w = sb_q.pop_front();
                    chk(rx_data == exp_w, "R5", "received word", int'(rx_data), int'(exp_w));
                end
            end
            prev_sclk = sclk;
            prev_cs   = cs_n;
        end
    end

    task automatic set_cfg(input int mode, input int div, input int sd, input int hd,
                           input bit keep, input bit inv_in);
        cfg_cpol      = mode[1];
        cfg_cpha      = mode[0];
        cfg_div       = DW'(div);
        cfg_setup_dly = 5'(sd);
        cfg_hold_dly  = 5'(hd);
        cfg_keep_cs   = keep;
        inv           = inv_in;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_all();
        int rises0;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n == 1'b1, "R9", "reset cs_n", cs_n, 1);
        chk(busy == 1'b0, "R9", "reset busy", busy, 0);
        chk(rx_valid == 1'b0, "R9", "reset rx_valid", rx_valid, 0);
        chk(tx_ready == 1'b1, "R9", "reset tx_ready", tx_ready, 1);
        chk(sclk == cfg_cpol, "R1", "reset sclk", sclk, cfg_cpol);

        // All four modes, two words each without keep (R1 R2 R3 R4 R5 R7).
        for (int m = 0; m < 4; m++) begin
            set_cfg(m, m, 3 * m, (5 * m) % 7, 1'b0, m[0]);
            exp_words = 1;
            rises0 = cs_rises;
            send(8'hA5 ^ 8'(m * 27));
            send(8'h3C ^ 8'(m));
            wait_idle();
            chk(cs_rises - rises0 == 2, "R7", "separate windows without keep", cs_rises - rises0, 2);
        end

        // Largest extra delays, fastest clock.
        set_cfg(1, 0, 31, 31, 1'b0, 1'b0);
        send(8'h81);
        wait_idle();
        set_cfg(2, 0, 31, 31, 1'b0, 1'b1);
        send(8'h7E);
        wait_idle();

        // Keep chip-select across three queued words (R7 R10).
        set_cfg(3, 2, 1, 2, 1'b1, 1'b0);
        exp_words = 3;
        rises0 = cs_rises;
        send(8'h12);
        send(8'hF0);
        send(8'h5A);
        wait_idle();
        chk(cs_rises - rises0 == 1, "R7", "one window with keep", cs_rises - rises0, 1);

        // Slave-ready gating (R8).
        set_cfg(0, 1, 0, 0, 1'b0, 1'b0);
        exp_words    = 1;
        cfg_rdy_mode = 1'b1;
        slv_rdy      = 1'b0;
        repeat (4) @(negedge clk);
        fork
            send(8'hC3);
        join_none
        repeat (20) @(negedge clk);
        chk(cs_n == 1'b1, "R8", "no start while not ready", cs_n, 1);
        chk(tx_ready == 1'b0, "R8", "tx_ready low while not ready", tx_ready, 0);
        slv_rdy = 1'b1;
        repeat (2) @(negedge clk);
        chk(cs_n == 1'b1, "R8", "cs_n two edges after ready", cs_n, 1);
        @(negedge clk);
        chk(cs_n == 1'b0, "R8", "cs_n three edges after ready", cs_n, 0);
        wait_idle();
        send(8'h96);
        wait_idle();
    endtask

    initial begin
        rst           = 1'b1;
        cfg_div       = '0;
        cfg_cpol      = 1'b0;
        cfg_cpha      = 1'b0;
        cfg_setup_dly = '0;
        cfg_hold_dly  = '0;
        cfg_keep_cs   = 1'b0;
        cfg_rdy_mode  = 1'b0;
        tx_valid      = 1'b0;
        tx_data       = '0;
        slv_rdy       = 1'b0;
        inv           = 1'b0;
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                chk(1'b0, "R9", "watchdog expired", 0, 1);
            end
        join_any
        disable fork;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule